// File: doc/BRIEF.md
# Ping-Pong Serial Shift-Out Engine

This block serializes 16-bit words onto a data pin and a shift clock pin. Two shadow words form a ping-pong buffer. Software writes either shadow on its own by placing a word on the write bus and pulsing that shadow's load strobe. While the engine shifts one shadow, software refills the other. The shadows are sent in turn, shadow 0 first, and each word leaves least-significant bit first.

The bit period comes from the core clock through two cascaded programmable dividers. The shift clock output is high for the first core cycle of each bit period, and the data pin changes on that same cycle.

A run starts when the enable input is high while the engine is idle. In free-running mode the engine keeps shifting until enable is cleared, and then finishes the word in progress. In fixed-count mode it sends a configured number of bits and then stops. The engine flags which shadow may be refilled, and it keeps a sticky flag if it ever had to send a shadow that was not reloaded.

Top module: `ppst_tx`

## Requirements
- R1: After reset, and whenever the engine is idle, `sclk_o`, `sdata_o` and `busy_o` are low.
- R2: A pulse on `load0_i` copies `wdata_i` into shadow 0 and a pulse on `load1_i` copies it into shadow 1. A load affects only its own shadow.
- R3: The bit period in core cycles is (`div_a_i`+1)*(`div_b_i`+1), using the values sampled when the run starts. `sclk_o` is high for exactly the first core cycle of every bit period, and one bit is launched in that cycle.
- R4: The first word comes from shadow 0, and the following words alternate between shadow 1 and shadow 0. Bit 0 of each word goes out first.
- R5: In free-running mode (`fixed_i`=0) shifting continues while `enable_i` is high. Once `enable_i` is seen low, the current word is finished and the engine goes idle, so a free run always sends a multiple of 16 bits.
- R6: In fixed-count mode (`fixed_i`=1) exactly `bit_count_i` bits are sent, with the count sampled at start, and then the engine goes idle. It does not start again until `enable_i` has been low. A count of 0 never starts a run.
- R7: `free_sel_o` gives the index of the shadow that is not being shifted: 1 right after start and 0 while shadow 1 is being shifted. It is 0 when idle.
- R8: `underrun_o` is set when a shadow that has not been loaded since it was last used starts being shifted. It stays set until the next run starts, and that run's own first word can set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 16 | Word to write into a shadow |
| load0_i | input | 1 | Load strobe for shadow 0 |
| load1_i | input | 1 | Load strobe for shadow 1 |
| enable_i | input | 1 | Starts a run; in free-running mode, clearing it requests a stop |
| fixed_i | input | 1 | 1 = fixed-count mode, 0 = free-running mode |
| bit_count_i | input | CNT_W | Number of bits to send in fixed-count mode |
| div_a_i | input | DIV_W | First divider stage, divides by value+1 |
| div_b_i | input | DIV_W | Second divider stage, divides by value+1 |
| sclk_o | output | 1 | Shift clock, one high core cycle per bit |
| sdata_o | output | 1 | Serial data |
| busy_o | output | 1 | A run is in progress |
| free_sel_o | output | 1 | Index of the shadow that may be reloaded |
| underrun_o | output | 1 | Sticky flag: a shadow was sent without being reloaded |

## Verification
Some properties are checked on every cycle. The divider counters must stay within their sampled limits, and the outputs must be quiet when idle. A shadow switch must happen only at a word boundary, and a free run must end only after bit 15. A fixed run must never exceed its count, and the underrun flag must stay set until a new start.

Other behaviour can only be shown by the bench's scenarios, which record every launched bit and the cycle it was launched in. These cover the exact bit order across shadow switches, the spacing of bit periods for several divider settings, and the point at which a free run drains after enable drops. They also cover fixed runs that end partway through a word, the refusal to restart while enable is held or when the count is zero, and an underrun that resends stale data.

// File: rtl/ppst_pkg.sv
package ppst_pkg;
  localparam int WORD_W = 16;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DRAIN = 2'd2
  } ppst_state_e;
endpackage

// File: rtl/ppst_div.sv
module ppst_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] lim_a_i,
  input  logic [DIV_W-1:0] lim_b_i,
  output logic             first_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_a_q, cnt_b_q;
  logic             wrap_a;

  assign wrap_a  = (cnt_a_q == lim_a_i);
  assign tick_o  = en_i && wrap_a && (cnt_b_q == lim_b_i);
  assign first_o = (cnt_a_q == '0) && (cnt_b_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_a_q <= '0;
      cnt_b_q <= '0;
    end else if (clr_i) begin
      cnt_a_q <= '0;
      cnt_b_q <= '0;
    end else if (en_i) begin
      cnt_a_q <= wrap_a ? '0 : cnt_a_q + 1'b1;
      if (wrap_a) cnt_b_q <= (cnt_b_q == lim_b_i) ? '0 : cnt_b_q + 1'b1;
    end
  end

  assert_div_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i |-> (cnt_a_q <= lim_a_i) && (cnt_b_q <= lim_b_i));
endmodule

// File: rtl/ppst_shadow.sv
module ppst_shadow
  import ppst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [1:0]        load_i,
  input  logic              rd_sel_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              take_i,
  input  logic              take_sel_i,
  output logic              rd_bit_o,
  output logic [1:0]        full_o
);
  logic [WORD_W-1:0] words [2];

  for (genvar g = 0; g < 2; g++) begin : g_sh
    logic [WORD_W-1:0] word_q;
    logic              full_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '0;
        full_q <= 1'b0;
      end else begin
        if (load_i[g]) word_q <= wdata_i;
        // a load in the same cycle as a take wins
        if (load_i[g])                                full_q <= 1'b1;
        else if (take_i && (take_sel_i == 1'(g)))     full_q <= 1'b0;
      end
    end

    assign words[g]  = word_q;
    assign full_o[g] = full_q;

    assert_load_copies_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i[g] |=> word_q == $past(wdata_i));
  end

  assign rd_bit_o = words[rd_sel_i][rd_idx_i];
endmodule

// File: rtl/ppst_tx.sv
module ppst_tx
  import ppst_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              load0_i,
  input  logic              load1_i,
  input  logic              enable_i,
  input  logic              fixed_i,
  input  logic [CNT_W-1:0]  bit_count_i,
  input  logic [DIV_W-1:0]  div_a_i,
  input  logic [DIV_W-1:0]  div_b_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              busy_o,
  output logic              free_sel_o,
  output logic              underrun_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  ppst_state_e      state_q;
  logic             cur_q, mode_q, hold_q, underrun_q, sdata_q;
  logic [IDX_W-1:0] bidx_q;
  logic [CNT_W-1:0] sent_q, cnt_q;
  logic [DIV_W-1:0] lim_a_q, lim_b_q;

  logic             run, start, tick, first, word_end, fix_done, free_stop, stop, adv, swap;
  logic             rd_sel, rd_bit, take, take_sel;
  logic [IDX_W-1:0] rd_idx;
  logic [1:0]       full;
  logic [CNT_W-1:0] sent_nx;

  assign run       = (state_q != ST_IDLE);
  assign start     = !run && enable_i && !hold_q && !(fixed_i && bit_count_i == '0);
  assign sent_nx   = sent_q + 1'b1;
  assign word_end  = tick && (bidx_q == LAST_IDX);
  assign fix_done  = run && mode_q && tick && (sent_nx == cnt_q);
  assign free_stop = run && !mode_q && word_end && (state_q == ST_DRAIN || !enable_i);
  assign stop      = fix_done || free_stop;
  assign adv       = run && tick && !stop;
  assign swap      = adv && word_end;

  // bit to launch at the next edge
  assign rd_sel   = start ? 1'b0 : (swap ? ~cur_q : cur_q);
  assign rd_idx   = (start || swap) ? '0 : bidx_q + 1'b1;
  assign take     = start || swap;
  assign take_sel = rd_sel;

  ppst_div #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start),
    .en_i    (run),
    .lim_a_i (lim_a_q),
    .lim_b_i (lim_b_q),
    .first_o (first),
    .tick_o  (tick)
  );

  ppst_shadow u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdata_i    (wdata_i),
    .load_i     ({load1_i, load0_i}),
    .rd_sel_i   (rd_sel),
    .rd_idx_i   (rd_idx),
    .take_i     (take),
    .take_sel_i (take_sel),
    .rd_bit_o   (rd_bit),
    .full_o     (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_q      <= 1'b0;
      mode_q     <= 1'b0;
      hold_q     <= 1'b0;
      underrun_q <= 1'b0;
      sdata_q    <= 1'b0;
      bidx_q     <= '0;
      sent_q     <= '0;
      cnt_q      <= '0;
      lim_a_q    <= '0;
      lim_b_q    <= '0;
    end else begin
      if (start) begin
        state_q <= ST_SHIFT;
        cur_q   <= 1'b0;
        bidx_q  <= '0;
        sent_q  <= '0;
        mode_q  <= fixed_i;
        cnt_q   <= bit_count_i;
        lim_a_q <= div_a_i;
        lim_b_q <= div_b_i;
        sdata_q <= rd_bit;
      end else if (stop) begin
        state_q <= ST_IDLE;
        sdata_q <= 1'b0;
        bidx_q  <= '0;
        cur_q   <= 1'b0;
      end else begin
        if (state_q == ST_SHIFT && !mode_q && !enable_i) state_q <= ST_DRAIN;
        if (adv) begin
          sdata_q <= rd_bit;
          bidx_q  <= rd_idx;
          cur_q   <= rd_sel;
          sent_q  <= sent_nx;
        end
      end

      if (fix_done)       hold_q <= 1'b1;
      else if (!enable_i) hold_q <= 1'b0;

      if (start)     underrun_q <= !full[0];
      else if (swap) underrun_q <= underrun_q || !full[take_sel];
    end
  end

  assign busy_o     = run;
  assign sclk_o     = run && first;
  assign sdata_o    = sdata_q;
  assign free_sel_o = run ? ~cur_q : 1'b0;
  assign underrun_o = underrun_q;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o && !sdata_o);
  assert_swap_at_word_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) && busy_o && (cur_q != $past(cur_q)) |-> $past(bidx_q) == LAST_IDX);
  assert_drain_whole_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) && !$past(mode_q) |-> $past(bidx_q) == LAST_IDX);
  assert_fixed_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && mode_q |-> sent_q < cnt_q);
  assert_sticky_underrun_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_q && !start |=> underrun_q);
endmodule

// File: tb/tb_ppst_tx.sv
module tb_ppst_tx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] wdata_i = '0;
  logic        load0_i = 1'b0, load1_i = 1'b0, enable_i = 1'b0, fixed_i = 1'b0;
  logic [15:0] bit_count_i = '0;
  logic [7:0]  div_a_i = '0, div_b_i = '0;
  logic        sclk_o, sdata_o, busy_o, free_sel_o, underrun_o;

  int n_chk = 0, n_fail = 0, cyc = 0, ncap = 0;
  logic cap_b [256];
  int   cap_t [256];

  always #2 clk_i = ~clk_i;

  ppst_tx dut (.*);

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (rst_ni && sclk_o && ncap < 256) begin
      cap_b[ncap] = sdata_o;
      cap_t[ncap] = cyc;
      ncap = ncap + 1;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] got_bits();
    logic [63:0] v = '0;
    for (int i = 0; i < 64 && i < ncap; i++) v[i] = cap_b[i];
    return v;
  endfunction

  function automatic int bad_gaps(int p);
    int bad = 0;
    for (int i = 1; i < ncap; i++) if (cap_t[i] - cap_t[i-1] != p) bad++;
    return bad;
  endfunction

  task automatic load(int sel, logic [15:0] w);
    @(negedge clk_i);
    wdata_i = w;
    if (sel == 0) load0_i = 1'b1; else load1_i = 1'b1;
    @(negedge clk_i);
    load0_i = 1'b0;
    load1_i = 1'b0;
  endtask

  task automatic wait_sel(logic v);
    while (free_sel_o !== v) @(negedge clk_i);
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 sclk idle", sclk_o, 0);
    chk("R1 sdata idle", sdata_o, 0);
    chk("R1 busy idle", busy_o, 0);
    chk("R8 underrun reset", underrun_o, 0);
    chk("R7 free_sel idle", free_sel_o, 0);
  endtask

  task automatic t_free_pingpong();
    div_a_i = 8'd2; div_b_i = 8'd0; fixed_i = 1'b0;
    load(0, 16'hA5C3);
    load(1, 16'h0F1E);
    ncap = 0;
    @(negedge clk_i); enable_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    chk("R7 free_sel after start", free_sel_o, 1);
    wait_sel(1'b0);
    load(0, 16'h8001);
    wait_sel(1'b1);
    load(1, 16'hFFFF);
    enable_i = 1'b0;
    wait_idle();
    chk("R5 free drain bit count", ncap, 48);
    chk("R4 R2 ping-pong LSB-first stream", got_bits() & 64'hFFFF_FFFF_FFFF,
        {16'h0, 16'h8001, 16'h0F1E, 16'hA5C3});
    chk("R3 period 3", bad_gaps(3), 0);
    chk("R8 no underrun", underrun_o, 0);
    chk("R1 sclk low after stop", sclk_o, 0);
    chk("R1 sdata low after stop", sdata_o, 0);
  endtask

  task automatic t_fixed();
    div_a_i = 8'd1; div_b_i = 8'd2; fixed_i = 1'b1; bit_count_i = 16'd20;
    load(0, 16'h1234);
    load(1, 16'h5A6B);
    ncap = 0;
    @(negedge clk_i); enable_i = 1'b1;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    chk("R6 fixed bit count", ncap, 20);
    chk("R6 fixed stream", got_bits() & 64'hF_FFFF, {4'hB, 16'h1234});
    chk("R3 period 6", bad_gaps(6), 0);
    repeat (40) @(negedge clk_i);
    chk("R6 no restart while enable held", ncap, 20);
    chk("R6 idle while enable held", busy_o, 0);
    enable_i = 1'b0;
    @(negedge clk_i);
    bit_count_i = 16'd0;
    enable_i = 1'b1;
    repeat (20) @(negedge clk_i);
    chk("R6 count zero never starts", busy_o, 0);
    chk("R6 count zero sends nothing", ncap, 20);
    enable_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_underrun();
    div_a_i = 8'd0; div_b_i = 8'd0; fixed_i = 1'b0;
    load(0, 16'hC0DE);
    ncap = 0;
    @(negedge clk_i); enable_i = 1'b1;
    @(negedge clk_i);
    wait_sel(1'b0);
    enable_i = 1'b0;
    wait_idle();
    chk("R8 underrun set on stale shadow", underrun_o, 1);
    chk("R8 stale shadow resent", got_bits() & 64'hFFFF_FFFF, {16'h5A6B, 16'hC0DE});
    chk("R3 period 1", bad_gaps(1), 0);
    repeat (10) @(negedge clk_i);
    chk("R8 underrun sticky while idle", underrun_o, 1);
  endtask

  task automatic t_cascade();
    div_a_i = 8'd3; div_b_i = 8'd1; fixed_i = 1'b0;
    load(0, 16'h7E81);
    load(1, 16'h3C96);
    ncap = 0;
    @(negedge clk_i); enable_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    chk("R8 underrun cleared by new start", underrun_o, 0);
    wait_sel(1'b0);
    enable_i = 1'b0;
    wait_idle();
    chk("R5 drain after second word", ncap, 32);
    chk("R4 cascade stream", got_bits() & 64'hFFFF_FFFF, {16'h3C96, 16'h7E81});
    chk("R3 period 8", bad_gaps(8), 0);
    chk("R8 no underrun", underrun_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_free_pingpong();
    t_fixed();
    t_underrun();
    t_cascade();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule